// File: doc/BRIEF.md
# Byte-to-Word Data FIFO Engine

This block sits between a host register interface and a card data path. It carries transfer data between a byte-wide card stream and a circular FIFO of 32-bit words, in either direction. A host write to the data control input arms a transfer: it sets the direction, turns the engine on and loads a byte countdown from the programmed 16-bit length.

When the card sends data to the host, incoming bytes are packed little-endian into words and pushed into the FIFO. The host pops them. When the host sends data to the card, the host pushes words and the engine unpacks each one into bytes, lowest byte first. The countdown falls by one for every byte that crosses the card port.

The engine reports a set of FIFO status flags, masked by the direction, together with sticky end-of-data flags and a remaining-word readout. It turns itself off once the countdown is zero and the FIFO is empty.

Top module: `byte_word_fifo_engine`

## Requirements
- R1: After reset the engine is off and the byte count is 0. `status_o` is 0, `card_rx_ready_o` and `card_tx_valid_o` are low, and both error pulses are low.
- R2: A cycle with `cfg_wr_i`=1 and `cfg_enable_i`=1 has these effects from the next cycle: `enable_o`=1, `byte_cnt_o`=`len_i`, and the direction is taken from `cfg_dir_i` (1 = card to host, 0 = host to card). A cycle with `cfg_wr_i`=1 and `cfg_enable_i`=0 turns the engine off and leaves the count unchanged.
- R3: In the card-to-host direction, successive accepted card bytes fill word bits 7:0, then 15:8, then 23:16, then 31:24. The word is pushed in the same cycle that its fourth byte is accepted.
- R4: If the count reaches zero partway through a word, the partial word is pushed at the last byte, with its unfilled upper bytes zero.
- R5: In the host-to-card direction, the engine pops a word and presents its bytes on `card_tx_data_o` lowest byte first, advancing 8 bits per accepted byte. Bytes left in the word when the count reaches zero are dropped.
- R6: `byte_cnt_o` falls by one for each byte that moves on the card port, at most one byte per clock. `word_cnt_o` equals (`byte_cnt_o` + 3) >> 2.
- R7: `card_rx_ready_o` is high only while the engine is on, the direction is card to host, the count is nonzero and the FIFO holds fewer than 16 words.
- R8: Once the engine is on with a count of zero, `status_o` bit 8 (data end) and bit 10 (block end) are set from the next cycle. They stay set until the next write that enables a transfer.
- R9: When the engine is on, the count is zero and the FIFO is empty, `enable_o` falls at the next edge. All FIFO flags read 0 whenever the count is zero and the FIFO is empty, and whenever the engine is off.
- R10: FIFO flags for a count of n words:
  - active is always set;
  - empty when n = 0;
  - data-available when n != 0;
  - full when n = 16;
  - half-empty when n <= 8;
  - half-full when n >= 8.

  The direction selects which set appears:
  - card to host: active bit 13, half-full bit 15, full bit 17, empty bit 19, available bit 21;
  - host to card: active bit 12, half-empty bit 14, full bit 16, empty bit 18, available bit 20.
- R11: A host push when the FIFO is full (host-to-card direction), and a host pop when it is empty (card-to-host direction), are ignored. Each raises `push_err_o` or `pop_err_o` for one cycle, in the following cycle. A host push in the card-to-host direction, and a host pop in the host-to-card direction, are ignored without an error.
- R12: The FIFO is circular, holds 16 words, and returns words in push order across pointer wrap-around. `host_pop_data_o` shows the oldest word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Data control write strobe |
| cfg_enable_i | input | 1 | Enable bit of the control write |
| cfg_dir_i | input | 1 | Direction bit of the control write, 1 = card to host |
| len_i | input | 16 | Programmed transfer length in bytes |
| host_push_i | input | 1 | Host pushes a word (host to card) |
| host_push_data_i | input | 32 | Word pushed by the host |
| host_pop_i | input | 1 | Host pops a word (card to host) |
| host_pop_data_o | output | 32 | Oldest FIFO word |
| card_rx_valid_i | input | 1 | Card byte valid |
| card_rx_data_i | input | 8 | Card byte |
| card_rx_ready_o | output | 1 | Engine accepts a card byte |
| card_tx_valid_o | output | 1 | Byte to card valid |
| card_tx_data_o | output | 8 | Byte to card |
| card_tx_ready_i | input | 1 | Card accepts the byte |
| status_o | output | 22 | End flags and direction-masked FIFO flags |
| enable_o | output | 1 | Engine on |
| byte_cnt_o | output | 16 | Remaining byte count |
| word_cnt_o | output | 15 | Remaining words, rounded up |
| push_err_o | output | 1 | Push-on-full pulse |
| pop_err_o | output | 1 | Pop-on-empty pulse |

## Verification
A card byte handshake, a host push or pop, or a control write changes the registered state at the same edge. The count, the FIFO contents, the flags and the handshake outputs therefore show the effect one cycle later, and the error pulses appear in the cycle after the offending request. A whole word is visible at the FIFO head one cycle after the byte that completes it. On the transmit side, a popped word reaches `card_tx_data_o` one cycle after the pop.

The bench keeps a behavioural reference that steps at each rising edge on the same inputs. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/bwf_pkg.sv
package bwf_pkg;
  localparam int STAT_W  = 22;
  localparam int S_DEND  = 8;
  localparam int S_BEND  = 10;
  localparam int S_TXACT = 12;
  localparam int S_RXACT = 13;
  localparam int S_TXHE  = 14;
  localparam int S_RXHF  = 15;
  localparam int S_TXFUL = 16;
  localparam int S_RXFUL = 17;
  localparam int S_TXEMP = 18;
  localparam int S_RXEMP = 19;
  localparam int S_TXAV  = 20;
  localparam int S_RXAV  = 21;
  typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/bwf_fifo.sv
module bwf_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];
  assign count_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_q] <= wdata_i;
  end

  assert_fifo_bound_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i && full_o && !pop_i |=> cnt_q == CW'(DEPTH));
  assert_no_underflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i && empty_o && !push_i |=> cnt_q == '0);
endmodule

// File: rtl/bwf_rx_pack.sv
module bwf_rx_pack #(
  parameter int W    = 32,
  localparam int BPW = W / 8,
  localparam int IW  = (BPW > 1) ? $clog2(BPW) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         fire_i,
  input  logic [7:0]   byte_i,
  input  logic         last_i,
  output logic         push_o,
  output logic [W-1:0] word_o
);
  logic [W-1:0]  acc_q;
  logic [IW-1:0] idx_q;

  assign word_o = acc_q | (W'(byte_i) << (8 * idx_q));
  assign push_o = fire_i & ((idx_q == IW'(BPW-1)) | last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (fire_i) begin
      if (push_o) begin
        acc_q <= '0;
        idx_q <= '0;
      end else begin
        acc_q <= word_o;
        idx_q <= idx_q + IW'(1);
      end
    end
  end

  // partial word leaves with the last byte, nothing lingers
  assert_pack_flush_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && last_i && !clear_i |=> idx_q == '0 && acc_q == '0);
endmodule

// File: rtl/bwf_tx_unpack.sv
module bwf_tx_unpack #(
  parameter int W    = 32,
  localparam int BPW = W / 8,
  localparam int NW  = $clog2(BPW+1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  input  logic         fire_i,
  output logic [7:0]   byte_o,
  output logic         have_o
);
  logic [W-1:0]  sh_q;
  logic [NW-1:0] left_q;

  assign byte_o = sh_q[7:0];
  assign have_o = (left_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (clear_i) begin
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= word_i;
      left_q <= NW'(BPW);
    end else if (fire_i) begin
      sh_q   <= sh_q >> 8;
      left_q <= left_q - NW'(1);
    end
  end

  assert_tx_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && !clear_i && !load_i |=> byte_o == $past(sh_q[15:8]));
endmodule

// File: rtl/bwf_flags.sv
module bwf_flags
  import bwf_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH+1)
) (
  input  logic          on_i,
  input  logic          dir_i,
  input  logic [CW-1:0] count_i,
  output stat_t         bits_o
);
  logic emp, av, ful, he, hf;

  assign emp = (count_i == '0);
  assign av  = ~emp;
  assign ful = (count_i == CW'(DEPTH));
  assign he  = (count_i <= CW'(DEPTH/2));
  assign hf  = (count_i >= CW'(DEPTH/2));

  always_comb begin
    bits_o = '0;
    if (on_i) begin
      if (dir_i) begin
        bits_o[S_RXACT] = 1'b1;
        bits_o[S_RXHF]  = hf;
        bits_o[S_RXFUL] = ful;
        bits_o[S_RXEMP] = emp;
        bits_o[S_RXAV]  = av;
      end else begin
        bits_o[S_TXACT] = 1'b1;
        bits_o[S_TXHE]  = he;
        bits_o[S_TXFUL] = ful;
        bits_o[S_TXEMP] = emp;
        bits_o[S_TXAV]  = av;
      end
    end
  end
endmodule

// File: rtl/byte_word_fifo_engine.sv
module byte_word_fifo_engine
  import bwf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int W      = 32,
  parameter int LEN_W  = 16,
  localparam int CW    = $clog2(DEPTH+1),
  localparam int WCW   = LEN_W - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_wr_i,
  input  logic             cfg_enable_i,
  input  logic             cfg_dir_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             host_push_i,
  input  logic [W-1:0]     host_push_data_i,
  input  logic             host_pop_i,
  output logic [W-1:0]     host_pop_data_o,
  input  logic             card_rx_valid_i,
  input  logic [7:0]       card_rx_data_i,
  output logic             card_rx_ready_o,
  output logic             card_tx_valid_o,
  output logic [7:0]       card_tx_data_o,
  input  logic             card_tx_ready_i,
  output logic [STAT_W-1:0] status_o,
  output logic             enable_o,
  output logic [LEN_W-1:0] byte_cnt_o,
  output logic [WCW-1:0]   word_cnt_o,
  output logic             push_err_o,
  output logic             pop_err_o
);
  logic             en_q, dir_q, end_q, perr_q, poperr_q;
  logic [LEN_W-1:0] cnt_q;
  logic             cnt_nz, arm;
  logic             f_push, f_pop, f_full, f_empty;
  logic [W-1:0]     f_wdata, f_rdata;
  logic [CW-1:0]    f_count;
  logic             pk_push;
  logic [W-1:0]     pk_word;
  logic             rx_fire, tx_fire, tx_load, tx_have;
  logic [7:0]       tx_byte;
  stat_t            fifo_bits;
  logic [LEN_W:0]   cnt_rnd;

  assign cnt_nz  = (cnt_q != '0);
  assign arm     = cfg_wr_i & cfg_enable_i;

  assign card_rx_ready_o = en_q & dir_q & cnt_nz & ~f_full;
  assign rx_fire = card_rx_ready_o & card_rx_valid_i;
  assign card_tx_valid_o = en_q & ~dir_q & cnt_nz & tx_have;
  assign tx_fire = card_tx_valid_o & card_tx_ready_i;
  assign tx_load = en_q & ~dir_q & cnt_nz & ~tx_have & ~f_empty;
  assign card_tx_data_o = tx_byte;

  assign f_push  = dir_q ? pk_push : host_push_i;
  assign f_wdata = dir_q ? pk_word : host_push_data_i;
  assign f_pop   = dir_q ? host_pop_i : tx_load;

  bwf_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(f_push), .wdata_i(f_wdata), .pop_i(f_pop),
    .rdata_o(f_rdata), .count_o(f_count), .full_o(f_full), .empty_o(f_empty)
  );

  bwf_rx_pack #(.W(W)) u_pack (
    .clk_i, .rst_ni, .clear_i(arm), .fire_i(rx_fire),
    .byte_i(card_rx_data_i), .last_i(cnt_q == LEN_W'(1)),
    .push_o(pk_push), .word_o(pk_word)
  );

  bwf_tx_unpack #(.W(W)) u_unpack (
    .clk_i, .rst_ni, .clear_i(arm), .load_i(tx_load), .word_i(f_rdata),
    .fire_i(tx_fire), .byte_o(tx_byte), .have_o(tx_have)
  );

  // flags drop once nothing is left to move
  bwf_flags #(.DEPTH(DEPTH)) u_flags (
    .on_i(en_q & (cnt_nz | ~f_empty)), .dir_i(dir_q), .count_i(f_count),
    .bits_o(fifo_bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      dir_q <= 1'b0;
      end_q <= 1'b0;
      cnt_q <= '0;
    end else if (cfg_wr_i) begin
      en_q  <= cfg_enable_i;
      dir_q <= cfg_dir_i;
      if (cfg_enable_i) begin
        cnt_q <= len_i;
        end_q <= 1'b0;
      end
    end else begin
      if (rx_fire | tx_fire) cnt_q <= cnt_q - LEN_W'(1);
      if (en_q & ~cnt_nz) end_q <= 1'b1;
      if (en_q & ~cnt_nz & f_empty) en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      perr_q   <= 1'b0;
      poperr_q <= 1'b0;
    end else begin
      perr_q   <= host_push_i & ~dir_q & f_full;
      poperr_q <= host_pop_i & dir_q & f_empty;
    end
  end

  assign cnt_rnd    = {1'b0, cnt_q} + (LEN_W+1)'(3);
  assign word_cnt_o = cnt_rnd[LEN_W:2];
  assign byte_cnt_o = cnt_q;
  assign enable_o   = en_q;
  assign push_err_o = perr_q;
  assign pop_err_o  = poperr_q;
  assign host_pop_data_o = f_rdata;

  always_comb begin
    status_o = fifo_bits;
    status_o[S_DEND] = end_q;
    status_o[S_BEND] = end_q;
  end

  assert_cnt_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_fire || tx_fire) && !cfg_wr_i |=> cnt_q == $past(cnt_q) - LEN_W'(1));
  assert_end_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !cnt_nz && !cfg_wr_i |=> status_o[S_DEND] && status_o[S_BEND]);
  assert_auto_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && !cnt_nz && f_empty && !cfg_wr_i |=> !enable_o);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm |=> enable_o && byte_cnt_o == $past(len_i));
  assert_one_side_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(card_rx_ready_o && card_tx_valid_o));
endmodule

// File: tb/tb_byte_word_fifo_engine.sv
`timescale 1ns/1ps
module tb_byte_word_fifo_engine;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        cfg_wr_i = 0, cfg_enable_i = 0, cfg_dir_i = 0;
  logic [15:0] len_i = 0;
  logic        host_push_i = 0;
  logic [31:0] host_push_data_i = 0;
  logic        host_pop_i = 0;
  logic [31:0] host_pop_data_o;
  logic        card_rx_valid_i = 0;
  logic [7:0]  card_rx_data_i = 0;
  logic        card_rx_ready_o, card_tx_valid_o;
  logic [7:0]  card_tx_data_o;
  logic        card_tx_ready_i = 0;
  logic [21:0] status_o;
  logic        enable_o;
  logic [15:0] byte_cnt_o;
  logic [14:0] word_cnt_o;
  logic        push_err_o, pop_err_o;

  always #5 clk_i = ~clk_i;

  byte_word_fifo_engine dut (.*);

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_q[$];
  bit          m_en, m_dir, m_end, m_perr, m_poperr;
  int          m_cnt, m_idx, m_left, bc;
  logic [31:0] m_acc, m_txw;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [21:0] exp_status();
    logic [21:0] s = '0;
    int n = m_q.size();
    if (m_en && (m_cnt != 0 || n != 0)) begin
      if (m_dir) begin
        s[13] = 1; s[15] = (n >= 8); s[17] = (n == 16); s[19] = (n == 0); s[21] = (n != 0);
      end else begin
        s[12] = 1; s[14] = (n <= 8); s[16] = (n == 16); s[18] = (n == 0); s[20] = (n != 0);
      end
    end
    s[8] = m_end; s[10] = m_end;
    return s;
  endfunction

  // reference step at each rising edge
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q.delete(); m_en = 0; m_dir = 0; m_end = 0; m_perr = 0; m_poperr = 0;
      m_cnt = 0; m_idx = 0; m_left = 0; m_acc = 0; m_txw = 0; bc = 1;
    end else begin
      bit full, empty, rx_f, tx_f, tx_l, en0;
      int cnt0;
      logic [31:0] w;
      full = (m_q.size() == 16); empty = (m_q.size() == 0);
      cnt0 = m_cnt; en0 = m_en;
      rx_f = m_en && m_dir && m_cnt != 0 && !full && card_rx_valid_i;
      tx_f = m_en && !m_dir && m_cnt != 0 && m_left != 0 && card_tx_ready_i;
      tx_l = m_en && !m_dir && m_cnt != 0 && m_left == 0 && !empty;
      m_perr = host_push_i && !m_dir && full;
      m_poperr = host_pop_i && m_dir && empty;
      // pops come from the current contents
      if (m_dir && host_pop_i && !empty) void'(m_q.pop_front());
      if (tx_l && !cfg_wr_i) begin m_txw = m_q.pop_front(); m_left = 4; end
      else if (tx_l) void'(m_q.pop_front());
      if (!m_dir && host_push_i && !full) m_q.push_back(host_push_data_i);
      if (rx_f) begin
        w = m_acc | (32'(card_rx_data_i) << (8 * m_idx));
        bc++;
        if (m_idx == 3 || m_cnt == 1) begin m_q.push_back(w); m_acc = 0; m_idx = 0; end
        else begin m_acc = w; m_idx++; end
      end
      if (cfg_wr_i) begin
        m_en = cfg_enable_i; m_dir = cfg_dir_i;
        if (cfg_enable_i) begin
          m_cnt = len_i; m_end = 0; m_acc = 0; m_idx = 0; m_left = 0;
        end
      end else begin
        if (tx_f) begin m_txw = m_txw >> 8; m_left--; end
        if (rx_f || tx_f) m_cnt--;
        if (en0 && cnt0 == 0) m_end = 1;
        if (en0 && cnt0 == 0 && empty) m_en = 0;
      end
    end
  end

  always @(negedge clk_i) card_rx_data_i <= bc[7:0];

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      logic exp_rdy, exp_val;
      exp_rdy = m_en && m_dir && m_cnt != 0 && m_q.size() < 16;
      exp_val = m_en && !m_dir && m_cnt != 0 && m_left != 0;
      check(status_o == exp_status(), "R8 R9 R10 status", 32'(status_o), 32'(exp_status()));
      check(enable_o == m_en, "R2 R9 enable", 32'(enable_o), 32'(m_en));
      check(byte_cnt_o == 16'(m_cnt), "R2 R6 byte count", 32'(byte_cnt_o), 32'(m_cnt));
      check(word_cnt_o == 15'((m_cnt + 3) >> 2), "R6 word count", 32'(word_cnt_o), 32'((m_cnt + 3) >> 2));
      check(card_rx_ready_o == exp_rdy, "R7 rx ready", 32'(card_rx_ready_o), 32'(exp_rdy));
      check(card_tx_valid_o == exp_val, "R5 tx valid", 32'(card_tx_valid_o), 32'(exp_val));
      if (exp_val)
        check(card_tx_data_o == m_txw[7:0], "R5 tx byte order", 32'(card_tx_data_o), 32'(m_txw[7:0]));
      if (m_q.size() != 0)
        check(host_pop_data_o == m_q[0], "R3 R4 R12 fifo head", host_pop_data_o, m_q[0]);
      check(push_err_o == m_perr, "R11 push error", 32'(push_err_o), 32'(m_perr));
      check(pop_err_o == m_poperr, "R11 pop error", 32'(pop_err_o), 32'(m_poperr));
    end
  end

  task automatic cfg(input bit en, input bit dir, input int len);
    cfg_wr_i = 1; cfg_enable_i = en; cfg_dir_i = dir; len_i = 16'(len);
    @(negedge clk_i);
    cfg_wr_i = 0; cfg_enable_i = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic pop(input int n);
    for (int i = 0; i < n; i++) begin host_pop_i = 1; @(negedge clk_i); end
    host_pop_i = 0;
  endtask

  task automatic push(input int n, input logic [31:0] base);
    for (int i = 0; i < n; i++) begin
      host_push_i = 1; host_push_data_i = base + 32'(i) * 32'h01010101;
      @(negedge clk_i);
    end
    host_push_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R1 reset state
    check(status_o == 0, "R1 status after reset", 32'(status_o), 0);
    check(!enable_o && byte_cnt_o == 0, "R1 idle after reset", 32'(byte_cnt_o), 0);
    check(!card_rx_ready_o && !card_tx_valid_o, "R1 handshakes low", 32'(card_rx_ready_o), 0);

    // R3 R4: card to host, 10 bytes, gappy valid
    cfg(1, 1, 10);
    for (int i = 0; i < 30; i++) begin card_rx_valid_i = (i % 3 != 2); @(negedge clk_i); end
    card_rx_valid_i = 0;
    check(host_pop_data_o == 32'h04030201, "R3 first packed word", host_pop_data_o, 32'h04030201);
    pop(3);
    pop(1); // R11 pop on empty
    idle(3);

    // R7 R12: 70 bytes, FIFO fills and wraps
    cfg(1, 1, 70);
    card_rx_valid_i = 1;
    idle(80);
    for (int k = 0; k < 20; k++) begin pop(1); idle(3); end
    pop(8);
    card_rx_valid_i = 0;
    push(2, 32'h55aa0000); // R11 push ignored in card-to-host direction
    idle(4);

    // R5: host to card, 9 bytes
    cfg(1, 0, 9);
    push(3, 32'hd4c3b2a1);
    for (int i = 0; i < 30; i++) begin card_tx_ready_i = (i % 4 != 1); @(negedge clk_i); end
    card_tx_ready_i = 0;
    idle(3);

    // R11: overflow on push, then drain
    cfg(1, 0, 200);
    push(18, 32'h10203040);
    card_tx_ready_i = 1;
    idle(100);
    card_tx_ready_i = 0;
    cfg(0, 0, 0);
    idle(3);

    // R8 R9: zero-length transfer
    cfg(1, 1, 0);
    idle(4);
    check(status_o[8] && status_o[10], "R8 end flags on zero length", 32'(status_o), 32'h500);
    check(!enable_o, "R9 auto off", 32'(enable_o), 0);

    // R4: 3-byte partial word
    cfg(1, 1, 3);
    card_rx_valid_i = 1;
    idle(6);
    card_rx_valid_i = 0;
    pop(1);
    idle(3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule